// File: doc/BRIEF.md
# Multi-format audio serial port

This block moves stereo audio between parallel sample registers and a serial line, in both directions. Playback pairs leave on a serial output towards a converter. Capture pairs arrive on a serial input from the other converter and are handed back as parallel words. The bit clock and the word clock come from an external timing master. Both are oversampled by the block's own system clock, so all internal logic runs in a single clock domain.

A 2-bit format code sets the sample width and the placement of each word inside its channel slot. Each slot lasts 32 bit-clock periods. In some formats playback and capture are placed differently within the same mode. Parallel words are always 20 bits wide. In 16-bit formats only bits [15:0] are meaningful.

A new playback pair is taken at the start of every frame, and the block acknowledges this with a one-cycle strobe. A capture pair is presented together with a one-cycle valid strobe once a left slot and the right slot after it have both been received.

Top module: `aud_serial_port`

## Requirements
- R1: While reset is asserted and right after its release, ser_out, play_take, cap_valid, cap_left and cap_right are all 0.
- R2: Format 00, playback: a 16-bit word taken from play bits [15:0] occupies slot positions 16..31 MSB first. Play bits [19:16] are ignored.
- R3: Format 01, playback: a 20-bit word occupies slot positions 12..31 MSB first.
- R4: Format 10, playback: a 20-bit word occupies slot positions 0..19 MSB first.
- R5: Format 11, playback: a 20-bit word occupies positions 1..20 MSB first, and word clock low marks the left slot. In formats 00, 01 and 10, word clock high marks the left slot. Slot position 0 is the first bit-clock period after a word-clock change.
- R6: Capture takes ser_in MSB first. In format 00 it takes 16 bits at positions 0..15 into cap bits [15:0], with [19:16] set to 0. In formats 01 and 10 it takes 20 bits at positions 0..19. In format 11 it takes 20 bits at positions 1..20. Bits at all other positions are ignored.
- R7: ser_out changes only after a falling edge of bit_clk and stays constant while bit_clk is high. ser_in is sampled at rising edges.
- R8: A playback pair is taken at the falling edge of bit_clk that opens the left slot. play_take pulses for one cycle at that moment. Later changes to play_left and play_right within the frame do not affect it.
- R9: cap_valid is a one-cycle pulse issued after the last data bit of a right slot, and only if the left slot before it was fully received. cap_left and cap_right change only together with cap_valid.
- R10: ser_out is 0 at every slot position outside the playback data window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than bit_clk |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_sel | input | 2 | Format code: 00, 01, 10, 11 as in R2..R6 |
| bit_clk | input | 1 | External serial bit clock |
| word_clk | input | 1 | External left/right word clock |
| ser_in | input | 1 | Serial capture data |
| play_left | input | 20 | Left playback sample |
| play_right | input | 20 | Right playback sample |
| play_take | output | 1 | One-cycle strobe: playback pair taken |
| ser_out | output | 1 | Serial playback data |
| cap_left | output | 20 | Last captured left sample |
| cap_right | output | 20 | Last captured right sample |
| cap_valid | output | 1 | One-cycle strobe: capture pair updated |

## Verification
Each of the four format codes is run with sample pairs whose bits [19:16] are set. This tells a 16-bit placement from a 20-bit one. Words with a lone bit at either end expose a window that is off by one position or placed at the wrong end of the slot. The capture stream is padded with ones outside the data window, so sampling a neighbouring position shows up as a wrong bit.

The playback inputs are inverted a few bits into each checked frame, which separates a frame-start latch from a transparent path. A lone right slot right after reset checks that no capture pair is reported without its left half.

// File: rtl/aud_pkg.sv
package aud_pkg;

  typedef logic [7:0] pos_t;

  typedef enum logic [1:0] {
    FMT_R16 = 2'b00,
    FMT_R20 = 2'b01,
    FMT_L20 = 2'b10,
    FMT_I2S = 2'b11
  } fmt_e;

  // Number of data bits carried per slot in the given format.
  function automatic pos_t word_len(fmt_e f, pos_t wmax, pos_t wshort);
    return (f == FMT_R16) ? wshort : wmax;
  endfunction

  // Slot position of the MSB. Playback is right-aligned in 00/01.
  function automatic pos_t first_pos(fmt_e f, logic is_tx, pos_t slot_len, pos_t len);
    if (f == FMT_I2S) return 8'd1;
    if (is_tx && (f != FMT_L20)) return slot_len - len;
    return 8'd0;
  endfunction

  function automatic logic in_window(pos_t pos, pos_t first, pos_t len);
    return (pos >= first) && ((pos - first) < len);
  endfunction

endpackage

// File: rtl/aud_sync.sv
module aud_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[gi]};
    end
    assign q[gi] = chain[STAGES-1];
  end
endmodule

// File: rtl/aud_slot_timer.sv
module aud_slot_timer
  import aud_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  input  logic lr_s,
  input  fmt_e fmt,
  output logic bit_rise,
  output logic bit_fall,
  output pos_t slot_pos,
  output logic slot_right,
  output logic frame_start
);
  logic bclk_d;
  logic lr_last;
  pos_t pos_q;

  assign bit_rise = bclk_s & ~bclk_d;
  assign bit_fall = ~bclk_s & bclk_d;

  // Position of the bit period now in progress (valid at either edge).
  always_comb begin
    if (lr_s != lr_last)      slot_pos = '0;
    else if (pos_q == '1)     slot_pos = pos_q;
    else                      slot_pos = pos_q + 8'd1;
  end

  assign slot_right  = (fmt == FMT_I2S) ? lr_s : ~lr_s;
  assign frame_start = bit_fall && (slot_pos == '0) && !slot_right;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      lr_last <= 1'b0;
      pos_q   <= '1;
    end else begin
      bclk_d <= bclk_s;
      if (bit_rise) begin
        pos_q   <= slot_pos;
        lr_last <= lr_s;
      end
    end
  end
endmodule

// File: rtl/aud_tx_path.sv
module aud_tx_path
  import aud_pkg::*;
#(
  parameter int WORD_MAX   = 20,
  parameter int WORD_SHORT = 16,
  parameter int SLOT_LEN   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_fall,
  input  logic                frame_start,
  input  pos_t                slot_pos,
  input  logic                slot_right,
  input  fmt_e                fmt,
  input  logic [WORD_MAX-1:0] play_l,
  input  logic [WORD_MAX-1:0] play_r,
  output logic                sdout,
  output logic                play_take
);
  localparam int   IDX_W   = $clog2(WORD_MAX);
  localparam pos_t WMAX_P  = pos_t'(WORD_MAX);
  localparam pos_t WSHRT_P = pos_t'(WORD_SHORT);
  localparam pos_t SLOT_P  = pos_t'(SLOT_LEN);

  logic [WORD_MAX-1:0] hold_l, hold_r, word;
  pos_t                len, first, offs;
  logic [IDX_W-1:0]    idx;
  logic                bit_d;

  always_comb begin
    len   = word_len(fmt, WMAX_P, WSHRT_P);
    first = first_pos(fmt, 1'b1, SLOT_P, len);
    word  = slot_right ? hold_r : (frame_start ? play_l : hold_l);
    offs  = slot_pos - first;
    idx   = IDX_W'(len - 8'd1 - offs);
    bit_d = in_window(slot_pos, first, len) ? word[idx] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l    <= '0;
      hold_r    <= '0;
      sdout     <= 1'b0;
      play_take <= 1'b0;
    end else begin
      play_take <= frame_start;
      if (frame_start) begin
        hold_l <= play_l;
        hold_r <= play_r;
      end
      if (bit_fall) sdout <= bit_d;
    end
  end
endmodule

// File: rtl/aud_rx_path.sv
module aud_rx_path
  import aud_pkg::*;
#(
  parameter int WORD_MAX   = 20,
  parameter int WORD_SHORT = 16,
  parameter int SLOT_LEN   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_rise,
  input  pos_t                slot_pos,
  input  logic                slot_right,
  input  fmt_e                fmt,
  input  logic                sdin,
  output logic                cap_last,
  output logic [WORD_MAX-1:0] cap_l,
  output logic [WORD_MAX-1:0] cap_r,
  output logic                cap_valid
);
  localparam pos_t WMAX_P  = pos_t'(WORD_MAX);
  localparam pos_t WSHRT_P = pos_t'(WORD_SHORT);
  localparam pos_t SLOT_P  = pos_t'(SLOT_LEN);

  logic [WORD_MAX-1:0] sh_l, sh_r, nxt_l, nxt_r;
  logic                left_done, take;
  pos_t                len, first, offs;

  always_comb begin
    len      = word_len(fmt, WMAX_P, WSHRT_P);
    first    = first_pos(fmt, 1'b0, SLOT_P, len);
    offs     = slot_pos - first;
    take     = bit_rise && in_window(slot_pos, first, len);
    cap_last = take && (offs == len - 8'd1);
    // The first bit of a window clears stale upper bits.
    nxt_l = (offs == '0) ? {{(WORD_MAX-1){1'b0}}, sdin} : {sh_l[WORD_MAX-2:0], sdin};
    nxt_r = (offs == '0) ? {{(WORD_MAX-1){1'b0}}, sdin} : {sh_r[WORD_MAX-2:0], sdin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_l      <= '0;
      sh_r      <= '0;
      cap_l     <= '0;
      cap_r     <= '0;
      cap_valid <= 1'b0;
      left_done <= 1'b0;
    end else begin
      cap_valid <= 1'b0;
      if (take) begin
        if (slot_right) begin
          sh_r <= nxt_r;
          if (cap_last && left_done) begin
            cap_l     <= sh_l;
            cap_r     <= nxt_r;
            cap_valid <= 1'b1;
            left_done <= 1'b0;
          end
        end else begin
          sh_l      <= nxt_l;
          left_done <= cap_last;
        end
      end
    end
  end
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_pkg::*;
#(
  parameter int WORD_MAX    = 20,
  parameter int WORD_SHORT  = 16,
  parameter int SLOT_LEN    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                bit_clk,
  input  logic                word_clk,
  input  logic                ser_in,
  input  logic [WORD_MAX-1:0] play_left,
  input  logic [WORD_MAX-1:0] play_right,
  output logic                play_take,
  output logic                ser_out,
  output logic [WORD_MAX-1:0] cap_left,
  output logic [WORD_MAX-1:0] cap_right,
  output logic                cap_valid
);
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] raw_in, synced;
  logic bclk_s, lr_s, sdin_s;
  logic bit_rise, bit_fall, slot_right, frame_start, cap_last;
  pos_t slot_pos;
  fmt_e fmt;

  assign fmt    = fmt_e'(fmt_sel);
  assign raw_in = {ser_in, word_clk, bit_clk};
  assign {sdin_s, lr_s, bclk_s} = synced;

  aud_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );

  aud_slot_timer u_timer (
    .clk(clk), .rst_n(rst_n), .bclk_s(bclk_s), .lr_s(lr_s), .fmt(fmt),
    .bit_rise(bit_rise), .bit_fall(bit_fall), .slot_pos(slot_pos),
    .slot_right(slot_right), .frame_start(frame_start)
  );

  aud_tx_path #(.WORD_MAX(WORD_MAX), .WORD_SHORT(WORD_SHORT), .SLOT_LEN(SLOT_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .frame_start(frame_start),
    .slot_pos(slot_pos), .slot_right(slot_right), .fmt(fmt),
    .play_l(play_left), .play_r(play_right), .sdout(ser_out), .play_take(play_take)
  );

  aud_rx_path #(.WORD_MAX(WORD_MAX), .WORD_SHORT(WORD_SHORT), .SLOT_LEN(SLOT_LEN)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .slot_pos(slot_pos),
    .slot_right(slot_right), .fmt(fmt), .sdin(sdin_s), .cap_last(cap_last),
    .cap_l(cap_left), .cap_r(cap_right), .cap_valid(cap_valid)
  );
endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk #(
  parameter int WORD_MAX = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ser_out,
  input logic                play_take,
  input logic                cap_valid,
  input logic                bit_fall,
  input logic                frame_start,
  input logic                cap_last,
  input logic [WORD_MAX-1:0] cap_left,
  input logic [WORD_MAX-1:0] cap_right
);
  // R7
  sdout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out) |-> $past(bit_fall));

  // R8
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_take |=> !play_take);

  // R8
  take_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_take |-> $past(frame_start));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> !cap_valid);

  // R9
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> $past(cap_last));

  // R9
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |-> ($stable(cap_left) && $stable(cap_right)));
endmodule

bind aud_serial_port aud_serial_port_chk #(.WORD_MAX(WORD_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_out(ser_out), .play_take(play_take),
  .cap_valid(cap_valid), .bit_fall(bit_fall), .frame_start(frame_start),
  .cap_last(cap_last), .cap_left(cap_left), .cap_right(cap_right)
);

// File: tb/test_aud_serial_port.sv
module test_aud_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b11;
  logic        bit_clk = 1'b0;
  logic        word_clk = 1'b1;
  logic        ser_in = 1'b0;
  logic [19:0] play_left = 20'hABCDE;
  logic [19:0] play_right = 20'h12345;
  logic        play_take, ser_out, cap_valid;
  logic [19:0] cap_left, cap_right;

  int n_cmp = 0;
  int n_bad = 0;
  int cap_cnt = 0;
  int take_cnt = 0;
  logic [19:0] seen_l, seen_r;

  always #4 clk = ~clk;

  aud_serial_port i_aud_serial_port (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bit_clk(bit_clk),
    .word_clk(word_clk), .ser_in(ser_in), .play_left(play_left),
    .play_right(play_right), .play_take(play_take), .ser_out(ser_out),
    .cap_left(cap_left), .cap_right(cap_right), .cap_valid(cap_valid)
  );

  always @(negedge clk) begin
    if (cap_valid) begin
      cap_cnt++;
      seen_l = cap_left;
      seen_r = cap_right;
    end
    if (play_take) take_cnt++;
  end

  typedef struct packed {
    logic [1:0]  m;
    logic [19:0] pl, pr, cl, cr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b00, 20'hF8001, 20'h37ACE, 20'h5A5A5, 20'hC0FFE},
    '{2'b00, 20'h0FFFF, 20'hA0000, 20'h08001, 20'hFFFFF},
    '{2'b01, 20'h80001, 20'h12345, 20'hABCDE, 20'h00001},
    '{2'b01, 20'hFFFFF, 20'h00000, 20'h55555, 20'hAAAAA},
    '{2'b10, 20'hC3A5F, 20'h80000, 20'h0F0F0, 20'h13579},
    '{2'b10, 20'h00001, 20'hFEDCB, 20'hFFFFF, 20'h00000},
    '{2'b11, 20'hBEEF1, 20'h54321, 20'h80001, 20'h2468A},
    '{2'b11, 20'h7FFFE, 20'h00010, 20'hDEAD5, 20'h99999}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Slot contents, MSB = position 0, as laid down by R2..R6.
  function automatic logic [31:0] place(input logic [1:0] m, input logic tx, input logic [19:0] w);
    case (m)
      2'b00:   return tx ? {16'h0, w[15:0]} : {w[15:0], 16'h0};
      2'b01:   return tx ? {12'h0, w} : {w, 12'h0};
      2'b10:   return {w, 12'h0};
      default: return {1'b0, w, 11'h0};
    endcase
  endfunction

  // One bit period: fall, low half, sample before rise, high half.
  task automatic drive_bit(input logic lvl, input logic din, output logic dout, output logic glitch);
    bit_clk = 1'b0;
    word_clk = lvl;
    ser_in = din;
    repeat (8) @(negedge clk);
    dout = ser_out;
    bit_clk = 1'b1;
    repeat (8) @(negedge clk);
    glitch = (ser_out !== dout);
  endtask

  task automatic run_frame(input logic [1:0] m, input logic [31:0] in_l, input logic [31:0] in_r,
                           input logic flip, output logic [31:0] ol, output logic [31:0] orr,
                           output int gl);
    logic lvl_left, b, g;
    lvl_left = (m == 2'b11) ? 1'b0 : 1'b1;
    gl = 0;
    for (int p = 0; p < 32; p++) begin
      drive_bit(lvl_left, in_l[31-p], b, g);
      ol[31-p] = b;
      gl += int'(g);
      if (flip && p == 4) begin
        play_left = ~play_left;
        play_right = ~play_right;
      end
    end
    for (int p = 0; p < 32; p++) begin
      drive_bit(~lvl_left, in_r[31-p], b, g);
      orr[31-p] = b;
      gl += int'(g);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] ol, orr, msk, sl, sr;
    logic [19:0] exp_cl, exp_cr;
    int gl, c0, t0;
    logic d, g;

    // R1: reset state, during and after reset
    repeat (10) @(negedge clk);
    check("R1 ser_out in reset", 32'(ser_out), 32'h0);
    check("R1 cap_valid in reset", 32'(cap_valid), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ser_out after reset", 32'(ser_out), 32'h0);
    check("R1 play_take after reset", 32'(play_take), 32'h0);
    check("R1 cap_left after reset", 32'(cap_left), 32'h0);
    check("R1 cap_right after reset", 32'(cap_right), 32'h0);

    // R9: a lone right slot must not produce a capture pair
    fmt_sel = 2'b11;
    for (int p = 0; p < 32; p++) drive_bit(1'b1, p[0], d, g);
    check("R9 no pair without left slot", 32'(cap_cnt), 32'h0);
    c0 = cap_cnt;
    t0 = take_cnt;
    run_frame(2'b11, place(2'b11, 1'b0, 20'h3C0F1), place(2'b11, 1'b0, 20'h8421F),
              1'b0, ol, orr, gl);
    check("R9 one pair after full frame", 32'(cap_cnt - c0), 32'h1);
    check("R9 left value", 32'(seen_l), 32'h3C0F1);
    check("R9 right value", 32'(seen_r), 32'h8421F);
    check("R8 one take per frame", 32'(take_cnt - t0), 32'h1);

    // Table of format vectors: frame 1 settles, frame 2 is checked
    foreach (VECS[i]) begin
      string rq;
      vec_t v;
      v = VECS[i];
      case (v.m)
        2'b00:   rq = "R2";
        2'b01:   rq = "R3";
        2'b10:   rq = "R4";
        default: rq = "R5";
      endcase
      fmt_sel = v.m;
      play_left = v.pl;
      play_right = v.pr;
      msk = place(v.m, 1'b0, 20'hFFFFF);
      sl = place(v.m, 1'b0, v.cl) | ~msk;  // R6: ones outside the window
      sr = place(v.m, 1'b0, v.cr) | ~msk;
      run_frame(v.m, sl, sr, 1'b0, ol, orr, gl);
      play_left = v.pl;
      play_right = v.pr;
      c0 = cap_cnt;
      t0 = take_cnt;
      run_frame(v.m, sl, sr, 1'b1, ol, orr, gl);
      // R2..R5, R8 and R10: whole slot compared, zeros outside window
      check({rq, " R8 R10 left slot"}, ol, place(v.m, 1'b1, v.pl));
      check({rq, " R8 R10 right slot"}, orr, place(v.m, 1'b1, v.pr));
      check("R8 take count", 32'(take_cnt - t0), 32'h1);
      check("R7 ser_out stable while bit_clk high", 32'(gl), 32'h0);
      exp_cl = (v.m == 2'b00) ? {4'h0, v.cl[15:0]} : v.cl;
      exp_cr = (v.m == 2'b00) ? {4'h0, v.cr[15:0]} : v.cr;
      check("R9 pair count", 32'(cap_cnt - c0), 32'h1);
      check("R6 capture left", 32'(seen_l), 32'(exp_cl));
      check("R6 capture right", 32'(seen_r), 32'(exp_cr));
    end

    finish_run();
  end
endmodule